// File: doc/BRIEF.md
# Repeating Status Byte Output Unit

This unit answers a status-read command on an 8-bit parallel output. When chip select goes low, the byte present on the command input at the first rising clock edge is taken as the opcode. If that byte is 57h, the unit drives a status byte from the next cycle on and keeps driving it for as long as chip select stays low. The other bits are reloaded on every clock edge, so each repetition carries fresh data.

The status byte has four parts. The top bit is a live ready flag, the inverse of the busy input from the command engine. The next bit holds the result of the most recent page-versus-buffer compare. Three bits carry a fixed density code. The three low bits are reserved and driven as zero. The ready bit is taken straight from the busy input and not from a register. A host can therefore stop the clock and poll that output line, which rises as soon as the busy operation ends.

Top module: `statRepeater`

## Requirements
- R1: While csN is low and the unit is idle, the first rising clock edge captures cmdByte. If it equals 57h, dataOe is high after that edge and dataOut carries a valid status byte. Later values of cmdByte in the same selection are ignored.
- R2: While dataOe is high, dataOut[7] equals the inverse of busy (1 = ready, 0 = busy). It follows busy without any clock edge, so a stopped clock still shows busy falling as dataOut[7] going from 0 to 1.
- R3: A cycle with cmpDone high stores cmpMismatch as the compare result (1 = some bit differed, 0 = match). The result holds until the next cmpDone and resets to 0. dataOut[6] shows the result that was stored before the most recent rising edge.
- R4: While dataOe is high, dataOut[5:3] equals the density code 3'b100.
- R5: While dataOe is high, the reserved bits dataOut[2:0] are 0.
- R6: Each rising edge with csN low during a status read reloads dataOut[6:0]. Repeated bytes therefore reflect status changes without a new opcode.
- R7: While csN is high, dataOe is 0 and dataOut is 0 at once, without waiting for a clock edge. The next low period of csN starts a new opcode capture.
- R8: If the captured opcode is not 57h, dataOe stays 0 for the whole selection.
- R9: After reset (rstN low), dataOe is 0 and the stored compare result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| cmdByte | input | 8 | Parallel command byte, captured as opcode on first edge of a selection |
| busy | input | 1 | Busy flag from the command engine |
| cmpDone | input | 1 | One-cycle strobe marking completion of a compare |
| cmpMismatch | input | 1 | Compare outcome, valid with cmpDone (1 = mismatch) |
| dataOut | output | 8 | Status byte, 0 when not driving |
| dataOe | output | 1 | Output enable for the status byte |

## Verification
The status byte is valid one rising edge after the opcode edge. The ready bit is combinational, and output enable and output data drop in the same delta as chip select rises. A compare result stored at edge k first shows in bit 6 after edge k+1. The bench drives every input on the falling edge and samples 1 ns after the next rising edge. For the live ready bit and the deselect it samples with the clock held still, so each expected value is bound to the exact edge that produces it.

// File: rtl/statPkg.sv
package statPkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OPC_STATUS = 8'h57;
  localparam logic [2:0] DENSITY_CODE = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STAT = 2'd1,
    ST_SKIP = 2'd2
  } statState_t;

  typedef struct packed {
    logic loadStat;
    logic outEn;
  } statStrobe_t;
endpackage

// File: rtl/statCtrl.sv
module statCtrl
  import statPkg::*;
#(
  parameter int W = BYTE_W,
  parameter logic [W-1:0] OPC = OPC_STATUS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic [W-1:0] cmdByte,
  output statStrobe_t  strb
);
  statState_t state, stateNext;
  logic opcMatch;

  assign opcMatch = (cmdByte == OPC);

  always_comb begin
    stateNext = state;
    if (csN) begin
      stateNext = ST_IDLE;
    end else if (state == ST_IDLE) begin
      stateNext = opcMatch ? ST_STAT : ST_SKIP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.loadStat = !csN && ((state == ST_IDLE && opcMatch) || state == ST_STAT);
    strb.outEn    = !csN && (state == ST_STAT);
  end
endmodule

// File: rtl/statDatapath.sv
module statDatapath
  import statPkg::*;
#(
  parameter int W = BYTE_W,
  parameter logic [2:0] DENS = DENSITY_CODE,
  localparam int LOW_W = W - 1,
  localparam int RSV_W = W - 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  statStrobe_t  strb,
  input  logic         busy,
  input  logic         cmpDone,
  input  logic         cmpMismatch,
  output logic [W-1:0] dataOut,
  output logic         dataOe
);
  logic cmpResult;
  logic [LOW_W-1:0] lowReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cmpResult <= 1'b0;
    else if (cmpDone) cmpResult <= cmpMismatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowReg <= '0;
    else if (strb.loadStat) lowReg <= {cmpResult, DENS, {RSV_W{1'b0}}};
  end

  assign dataOe  = strb.outEn;
  assign dataOut = strb.outEn ? {!busy, lowReg} : '0;
endmodule

// File: rtl/statRepeater.sv
module statRepeater
  import statPkg::*;
#(
  parameter int W = BYTE_W,
  parameter logic [W-1:0] OPC = OPC_STATUS,
  parameter logic [2:0] DENS = DENSITY_CODE
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic [W-1:0] cmdByte,
  input  logic         busy,
  input  logic         cmpDone,
  input  logic         cmpMismatch,
  output logic [W-1:0] dataOut,
  output logic         dataOe
);
  statStrobe_t strb;

  statCtrl #(.W(W), .OPC(OPC)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdByte(cmdByte), .strb(strb)
  );

  statDatapath #(.W(W), .DENS(DENS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .cmpDone(cmpDone), .cmpMismatch(cmpMismatch),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/statRepeaterChk.sv
module statRepeaterChk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [7:0] cmdByte,
  input logic       busy,
  input logic [7:0] dataOut,
  input logic       dataOe
);
  // R7
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!dataOe && dataOut == 8'h00));

  // R4
  density_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> dataOut[5:3] == 3'b100);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> dataOut[2:0] == 3'b000);

  // R1
  opcode_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> ($past(cmdByte) == 8'h57 && !$past(csN) && !$past(dataOe)));

  // R2
  ready_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> dataOut[7] == !busy);
endmodule

bind statRepeater statRepeaterChk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .cmdByte(cmdByte),
  .busy(busy), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/statRepeater_tb.sv
`timescale 1ns/1ps
module statRepeater_tb;
  logic clk = 1'b0;
  logic clkRun = 1'b1;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic [7:0] cmdByte = 8'h00;
  logic busy = 1'b0;
  logic cmpDone = 1'b0;
  logic cmpMismatch = 1'b0;
  logic [7:0] dataOut;
  logic dataOe;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always begin
    #2.5;
    if (clkRun) clk = ~clk;
  end

  statRepeater u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdByte(cmdByte), .busy(busy),
    .cmpDone(cmpDone), .cmpMismatch(cmpMismatch), .dataOut(dataOut), .dataOe(dataOe)
  );

  // {busy, cmpDone, cmpMismatch, expected byte after edge}
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'h20},
    {1'b1, 1'b1, 1'b1, 8'h20},
    {1'b1, 1'b0, 1'b0, 8'h60},
    {1'b0, 1'b0, 1'b0, 8'hE0},
    {1'b0, 1'b1, 1'b0, 8'hE0},
    {1'b0, 1'b0, 1'b0, 8'hA0},
    {1'b1, 1'b1, 1'b1, 8'h20},
    {1'b0, 1'b0, 1'b0, 8'hE0}
  };

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic edgeThenSample();
    @(posedge clk);
    #1;
  endtask

  task automatic startSel(input logic [7:0] opc);
    @(negedge clk);
    csN = 1'b0;
    cmdByte = opc;
    edgeThenSample();
  endtask

  task automatic endSel();
    @(negedge clk);
    csN = 1'b1;
    cmdByte = 8'h00;
    #1;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired got=hung expected=done");
    finish();
  end

  initial begin
    #12;
    chk("R9 reset oe/out", {dataOe, dataOut}, 9'h000);
    @(negedge clk);
    rstN = 1'b1;

    // R1: opcode capture, byte valid next cycle
    startSel(8'h57);
    chk("R1 first status byte", {dataOe, dataOut}, {1'b1, 8'hA0});

    // Vector walk: R3 / R6 repetition with fresh data, R2 ready bit
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busy = VEC[i][10];
      cmpDone = VEC[i][9];
      cmpMismatch = VEC[i][8];
      if (i == 2) cmdByte = 8'h00; // R1: later bytes ignored
      edgeThenSample();
      chk("R6/R3 repeated byte", {dataOe, dataOut}, {1'b1, VEC[i][7:0]});
    end
    @(negedge clk);
    cmpDone = 1'b0;

    // R2: polling with stopped clock (clock is low here)
    busy = 1'b1;
    clkRun = 1'b0;
    #3;
    chk("R2 poll busy", {8'h00, dataOut[7]}, 9'h000);
    #20;
    busy = 1'b0;
    #1;
    chk("R2 poll ready rise", {8'h00, dataOut[7]}, 9'h001);
    chk("R4/R5 fields while frozen", {6'h00, dataOut[5:3]}, 9'h004);

    // R7: deselect while clock frozen
    csN = 1'b1;
    #1;
    chk("R7 deselect immediate", {dataOe, dataOut}, 9'h000);
    #5;
    clkRun = 1'b1;
    edgeThenSample();
    chk("R7 stays quiet", {dataOe, dataOut}, 9'h000);

    // R8: other opcode never enables
    startSel(8'h53);
    chk("R8 other opcode cycle1", {8'h00, dataOe}, 9'h000);
    @(negedge clk);
    cmdByte = 8'h57;
    edgeThenSample();
    chk("R8 other opcode cycle2", {8'h00, dataOe}, 9'h000);
    endSel();

    // R7: new selection works after deselect; compare result held (1)
    startSel(8'h57);
    chk("R7/R3 new selection", {dataOe, dataOut}, {1'b1, 8'hE0});
    endSel();

    // R9: reset clears compare result
    rstN = 1'b0;
    #2;
    chk("R9 reset mid-run", {dataOe, dataOut}, 9'h000);
    @(negedge clk);
    rstN = 1'b1;
    startSel(8'h57);
    chk("R9 compare cleared", {dataOe, dataOut}, {1'b1, 8'hA0});
    chk("R5 reserved zero", {6'h00, dataOut[2:0]}, 9'h000);
    endSel();
    finish();
  end
endmodule